// File: doc/BRIEF.md
# Serial EEPROM Slave Model

This block is a synthesizable model of a small byte-addressable serial EEPROM that answers on an SPI bus in mode 0. A host lowers chip select, shifts in a command byte, an optional big-endian address and optional data, and reads results back on the serial output. The memory array, page size, address length and the length of the internal programming interval are all parameters. The model is meant for system-level benches and emulation builds that need a realistic storage target: one that has a write-enable latch, page-wrapping writes and a busy interval that software has to poll.

The serial pins are resampled by the block's own system clock. SCK must therefore stay in each level for several system clocks. Data written to the array lands as each complete byte arrives. The programming interval starts when chip select is released.

Top module: `spi_eeprom_model`

## Requirements
- R1: Each frame starts when csN falls. Bits are taken MSB first on SCK rising edges. The first byte is the command: 0x06 sets the write latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads memory and 0x02 writes memory. For the two memory commands, ADDR_BYTES address bytes follow, most significant byte first, and only the low log2(MEM_BYTES) bits of the address are used.
- R2: After reset the status byte reads 0x00, every memory byte reads 0xFF, and miso is low whenever csN is high.
- R3: A memory read shifts out one byte per eight SCK cycles for as long as csN stays low. It starts at the given address, moves to the next address after each byte, and wraps from the last address to 0. Each bit changes on an SCK falling edge, and the first bit is valid before the first rising edge of the data phase.
- R4: The status byte has busy in bit 0, the write latch in bit 1, two protect-level bits in bits 3:2 and a protect-enable bit in bit 7. Bits 6:4 read 0. A status read returns the current status in every byte until csN rises.
- R5: Command 0x06 sets the write latch and command 0x04 clears it, each once its command byte is complete.
- R6: A memory write or status write is accepted only while the write latch is set. Otherwise the frame leaves memory and status unchanged.
- R7: Within a memory write, each data byte goes to the next address inside the same page, whose size is PAGE_BYTES. After the last byte of the page it wraps to the first byte of that page, and never into the neighbouring page.
- R8: When csN rises at the end of an accepted memory write or status write, the write latch clears and busy reads 1 for WRITE_CYCLES system clocks, then reads 0.
- R9: While busy is set, only the status read takes effect. Every other command is ignored, and a memory read returns 0x00.
- R10: If csN rises partway through a data byte of a memory write, that partial byte is not stored.
- R11: A status write changes only bits 7, 3 and 2, copying them from the data byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to resample the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select; a low period is one frame |
| sck | input | 1 | Serial clock, idle low (mode 0) |
| mosi | input | 1 | Serial data from the host, sampled on SCK rising edges |
| miso | output | 1 | Serial data to the host, updated on SCK falling edges; low while deselected |

## Verification
A fault in the bit or byte counters shows up within one frame: the command is decoded wrongly, and the status byte or the read data read back rotated or from the wrong address. A wrong page-wrap or address-increment rule does not show at write time. It shows only when the affected region is read back, so every write pattern is followed by a read that covers the page boundary and the first byte of the neighbouring page. A latch or busy flag left in the wrong state shows up in the next status poll. It also shows as a write or write-enable that should have been refused but was carried out, which becomes visible only after the programming interval has ended.

// File: rtl/spiee_pkg.sv
package spiee_pkg;

  localparam logic [7:0] CMD_WEN_SET = 8'h06;
  localparam logic [7:0] CMD_WEN_CLR = 8'h04;
  localparam logic [7:0] CMD_STAT_RD = 8'h05;
  localparam logic [7:0] CMD_STAT_WR = 8'h01;
  localparam logic [7:0] CMD_MEM_RD  = 8'h03;
  localparam logic [7:0] CMD_MEM_WR  = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RD, ST_WR, ST_SRD, ST_SWR, ST_IGN
  } eeState_t;

  typedef struct packed {
    logic addrByte;   // shift a received byte into the address
    logic addrLast;   // final address byte: load the byte pointer
    logic rdLoad;     // fetch memory byte into the output shifter
    logic wrByte;     // store received byte at the pointer
    logic srLoad;     // copy status into the output shifter
    logic srWrite;    // update protect fields from the received byte
    logic setWel;
    logic clrWel;
    logic startBusy;  // frame closed on an accepted write
    logic shiftOut;   // SCK falling edge while selected
    logic clearOut;   // deselected
  } eeStrobe_t;

endpackage

// File: rtl/spiee_ctrl.sv
module spiee_ctrl
  import spiee_pkg::*;
#(
  parameter int ADDR_BYTES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       mosi,
  input  logic       busy,
  input  logic       wel,
  output eeStrobe_t  strb,
  output logic [7:0] rxByte
);

  localparam int ACW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  logic [1:0] csSync, sckSync, mosiSync;
  logic       sckPrev, csActPrev;
  logic       csActive, sckRise, sckFall, frameStart, frameEnd, byteDone;
  logic [2:0] bitCnt;
  logic [6:0] shIn;
  logic [ACW-1:0] byteCnt, byteCntNext;
  logic       isWr, isWrNext;
  eeState_t   state, stateNext;

  assign csActive   = ~csSync[1];
  assign sckRise    = csActive & sckSync[1] & ~sckPrev;
  assign sckFall    = csActive & ~sckSync[1] & sckPrev;
  assign frameStart = csActive & ~csActPrev;
  assign frameEnd   = ~csActive & csActPrev;
  assign byteDone   = sckRise && (bitCnt == 3'd7);
  assign rxByte     = {shIn, mosiSync[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync    <= 2'b11;
      sckSync   <= '0;
      mosiSync  <= '0;
      sckPrev   <= 1'b0;
      csActPrev <= 1'b0;
      state     <= ST_IDLE;
      bitCnt    <= '0;
      shIn      <= '0;
      byteCnt   <= '0;
      isWr      <= 1'b0;
    end else begin
      csSync    <= {csSync[0], csN};
      sckSync   <= {sckSync[0], sck};
      mosiSync  <= {mosiSync[0], mosi};
      sckPrev   <= sckSync[1];
      csActPrev <= csActive;
      state     <= stateNext;
      byteCnt   <= byteCntNext;
      isWr      <= isWrNext;
      if (frameStart) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        bitCnt <= bitCnt + 3'd1;
        shIn   <= {shIn[5:0], mosiSync[1]};
      end
    end
  end

  always_comb begin
    strb          = '0;
    stateNext     = state;
    byteCntNext   = byteCnt;
    isWrNext      = isWr;
    strb.shiftOut = sckFall;
    strb.clearOut = ~csActive;
    if (frameEnd) begin
      strb.startBusy = (state == ST_WR) || (state == ST_SWR);
      stateNext      = ST_IDLE;
    end else if (frameStart) begin
      stateNext   = ST_OPC;
      byteCntNext = '0;
    end else if (byteDone) begin
      unique case (state)
        ST_OPC: begin
          if (busy) begin
            if (rxByte == CMD_STAT_RD) begin
              strb.srLoad = 1'b1;
              stateNext   = ST_SRD;
            end else begin
              stateNext = ST_IGN;
            end
          end else begin
            case (rxByte)
              CMD_WEN_SET: begin strb.setWel = 1'b1; stateNext = ST_IGN; end
              CMD_WEN_CLR: begin strb.clrWel = 1'b1; stateNext = ST_IGN; end
              CMD_STAT_RD: begin strb.srLoad = 1'b1; stateNext = ST_SRD; end
              CMD_STAT_WR: stateNext = wel ? ST_SWR : ST_IGN;
              CMD_MEM_RD: begin
                stateNext = ST_ADDR;
                isWrNext  = 1'b0;
              end
              CMD_MEM_WR: begin
                stateNext = wel ? ST_ADDR : ST_IGN;
                isWrNext  = 1'b1;
              end
              default: stateNext = ST_IGN;
            endcase
          end
        end
        ST_ADDR: begin
          strb.addrByte = 1'b1;
          if (byteCnt == ACW'(ADDR_BYTES - 1)) begin
            strb.addrLast = 1'b1;
            if (isWr) begin
              stateNext = ST_WR;
            end else begin
              strb.rdLoad = 1'b1;
              stateNext   = ST_RD;
            end
          end else begin
            byteCntNext = byteCnt + 1'b1;
          end
        end
        ST_RD:   strb.rdLoad  = 1'b1;
        ST_SRD:  strb.srLoad  = 1'b1;
        ST_WR:   strb.wrByte  = 1'b1;
        ST_SWR:  strb.srWrite = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spiee_data.sv
module spiee_data
  import spiee_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  eeStrobe_t  strb,
  input  logic [7:0] rxByte,
  output logic       busy,
  output logic       wel,
  output logic       miso
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int CW = $clog2(WRITE_CYCLES + 1);
  localparam logic [AW-1:0] PMASK = AW'(PAGE_BYTES - 1);

  logic [7:0]    mem [MEM_BYTES];
  logic [AW-1:0] addrAcc, newAddr, curAddr, srcAddr, wrNext;
  logic [CW-1:0] busyCnt;
  logic [1:0]    protLvl;
  logic          protEn;
  logic [7:0]    outReg, statusVal;
  logic          misoQ;

  assign busy      = (busyCnt != '0);
  assign statusVal = {protEn, 3'b000, protLvl, wel, busy};
  assign newAddr   = AW'({addrAcc, rxByte});
  assign srcAddr   = strb.addrLast ? newAddr : curAddr;
  assign wrNext    = (curAddr & ~PMASK) | ((curAddr + 1'b1) & PMASK);
  assign miso      = misoQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (strb.wrByte) begin
      mem[curAddr] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrAcc <= '0;
      curAddr <= '0;
      busyCnt <= '0;
      wel     <= 1'b0;
      protLvl <= '0;
      protEn  <= 1'b0;
      outReg  <= '0;
      misoQ   <= 1'b0;
    end else begin
      if (busyCnt != '0) busyCnt <= busyCnt - 1'b1;
      if (strb.setWel) wel <= 1'b1;
      if (strb.clrWel) wel <= 1'b0;
      if (strb.startBusy) begin
        busyCnt <= CW'(WRITE_CYCLES);
        wel     <= 1'b0;
      end
      if (strb.addrByte) addrAcc <= newAddr;
      if (strb.addrLast) curAddr <= newAddr;
      if (strb.rdLoad) begin
        outReg  <= mem[srcAddr];
        curAddr <= srcAddr + 1'b1;
      end
      if (strb.wrByte) curAddr <= wrNext;
      if (strb.srLoad) outReg <= statusVal;
      if (strb.srWrite) begin
        protEn  <= rxByte[7];
        protLvl <= rxByte[3:2];
      end
      if (strb.clearOut) begin
        outReg <= '0;
        misoQ  <= 1'b0;
      end else if (strb.shiftOut) begin
        misoQ  <= outReg[7];
        outReg <= {outReg[6:0], 1'b0};
      end
    end
  end

  // R6
  wr_needs_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrByte || strb.srWrite) |-> (wel && !busy));

  // R7
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrByte |=> ((curAddr & ~PMASK) == $past(curAddr & ~PMASK)));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startBusy |-> (wel && !busy));

  // R9
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.setWel || strb.clrWel || strb.rdLoad || strb.wrByte || strb.srWrite));

  // R2
  miso_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearOut |=> !miso);

endmodule

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model
  import spiee_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int PAGE_BYTES   = 16,
  parameter int ADDR_BYTES   = 2,
  parameter int WRITE_CYCLES = 500
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  output logic miso
);

  eeStrobe_t  strb;
  logic [7:0] rxByte;
  logic       busy, wel;

  spiee_ctrl #(.ADDR_BYTES(ADDR_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .busy(busy), .wel(wel), .strb(strb), .rxByte(rxByte)
  );

  spiee_data #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte),
    .busy(busy), .wel(wel), .miso(miso)
  );

endmodule

// File: tb/spi_eeprom_model_tb.sv
module spi_eeprom_model_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 6;
  localparam int MEMB  = 64;
  localparam int PAGEB = 8;
  localparam int ADDRB = 2;
  localparam int WCYC  = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;

  int nRun = 0;
  int nFail = 0;
  logic [7:0] model [MEMB];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_eeprom_model #(
    .MEM_BYTES(MEMB), .PAGE_BYTES(PAGEB), .ADDR_BYTES(ADDRB), .WRITE_CYCLES(WCYC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idleClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xferBits(input logic [7:0] tx, input int nBits, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - nBits; b--) begin
      mosi = tx[b];
      idleClk(HALF_SCK);
      rx[b] = miso;
      sck = 1'b1;
      idleClk(HALF_SCK);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xferBits(tx, 8, rx);
  endtask

  task automatic beginFrame();
    csN = 1'b0;
    idleClk(HALF_SCK);
  endtask

  task automatic endFrame();
    idleClk(HALF_SCK);
    csN = 1'b1;
    idleClk(2 * HALF_SCK);
  endtask

  task automatic sendAddr(input int a);
    logic [7:0] d;
    for (int i = ADDRB - 1; i >= 0; i--) xfer(8'((a >> (8 * i)) & 8'hFF), d);
  endtask

  task automatic simpleCmd(input logic [7:0] op);
    logic [7:0] d;
    beginFrame();
    xfer(op, d);
    endFrame();
  endtask

  task automatic statusIs(input string tag, input logic [7:0] exp);
    logic [7:0] d;
    beginFrame();
    xfer(8'h05, d);
    xfer(8'h00, d);
    endFrame();
    check8(tag, d, exp);
  endtask

  task automatic checkRead(input string tag, input int a, input int n);
    logic [7:0] d;
    beginFrame();
    xfer(8'h03, d);
    sendAddr(a);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d);
      check8(tag, d, model[(a + i) % MEMB]);
    end
    endFrame();
  endtask

  function automatic int pageSlot(input int a, input int i);
    return ((a % MEMB) & ~(PAGEB - 1)) | ((a + i) & (PAGEB - 1));
  endfunction

  function automatic logic [7:0] pattern(input int a, input int seed);
    return 8'((a * 37 + seed * 11 + 5) & 8'hFF);
  endfunction

  // accept=1: model follows the write; partBits>0 appends an incomplete byte
  task automatic writeBlock(input int a, input int n, input int seed,
                            input bit accept, input int partBits);
    logic [7:0] d, v;
    beginFrame();
    xfer(8'h02, d);
    sendAddr(a);
    for (int i = 0; i < n; i++) begin
      v = pattern(i, seed);
      xfer(v, d);
      if (accept) model[pageSlot(a, i)] = v;
    end
    if (partBits > 0) xferBits(8'h5A, partBits, d);
    endFrame();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < MEMB; i++) model[i] = 8'hFF;
    idleClk(5);
    rstN = 1'b1;
    idleClk(5);

    // R2 reset state
    check8("R2 miso idle", {7'd0, miso}, 8'h00);
    statusIs("R2 status after reset", 8'h00);
    checkRead("R2 erased array", 0, 3);

    // R6 write without the latch is refused
    writeBlock(3, 2, 1, 1'b0, 0);
    idleClk(WCYC + 10);
    statusIs("R6 no busy after refused write", 8'h00);
    checkRead("R6 refused write leaves data", 2, 4);

    // R5 latch set and clear
    simpleCmd(8'h06);
    statusIs("R5 latch set", 8'h02);
    simpleCmd(8'h04);
    statusIs("R5 latch cleared", 8'h00);

    // R1 R8 basic write, busy window
    simpleCmd(8'h06);
    writeBlock(5, 3, 2, 1'b1, 0);
    statusIs("R8 busy set, latch cleared", 8'h01);
    idleClk(WCYC);
    statusIs("R8 busy released", 8'h00);
    checkRead("R1 basic write readback", 4, 6);

    // R7 page wrap
    simpleCmd(8'h06);
    writeBlock(21, 10, 3, 1'b1, 0);
    idleClk(WCYC + 10);
    checkRead("R7 page wrap", 15, 11);

    // R9 commands ignored while busy
    simpleCmd(8'h06);
    writeBlock(30, 1, 4, 1'b1, 0);
    simpleCmd(8'h06);
    statusIs("R9 set-latch ignored while busy", 8'h01);
    beginFrame();
    xfer(8'h03, d);
    sendAddr(30);
    xfer(8'h00, d);
    endFrame();
    check8("R9 read while busy returns zero", d, 8'h00);
    idleClk(WCYC);
    statusIs("R9 latch still clear after busy", 8'h00);
    checkRead("R9 write landed", 30, 1);

    // R10 incomplete byte dropped
    simpleCmd(8'h06);
    writeBlock(40, 1, 5, 1'b1, 5);
    idleClk(WCYC + 10);
    checkRead("R10 partial byte not stored", 40, 3);

    // R11 R4 R6 status write
    simpleCmd(8'h06);
    beginFrame(); xfer(8'h01, d); xfer(8'hFF, d); endFrame();
    idleClk(WCYC + 10);
    statusIs("R11 status write masks bits", 8'h8C);
    beginFrame(); xfer(8'h01, d); xfer(8'h00, d); endFrame();
    idleClk(WCYC + 10);
    statusIs("R6 status write needs latch", 8'h8C);
    simpleCmd(8'h06);
    beginFrame(); xfer(8'h01, d); xfer(8'h00, d); endFrame();
    idleClk(WCYC + 10);
    statusIs("R11 status cleared", 8'h00);

    // R4 repeated status bytes
    simpleCmd(8'h06);
    beginFrame();
    xfer(8'h05, d);
    for (int i = 0; i < 3; i++) begin
      xfer(8'h00, d);
      check8("R4 status repeats", d, 8'h02);
    end
    endFrame();
    simpleCmd(8'h04);

    // R1 R7 sweep every page
    for (int p = 0; p < MEMB / PAGEB; p++) begin
      simpleCmd(8'h06);
      writeBlock(p * PAGEB, PAGEB, 6 + p, 1'b1, 0);
      idleClk(WCYC + 10);
    end
    checkRead("R1 full array sweep", 0, MEMB);

    // R3 read wraps at the end of the array
    checkRead("R3 end-of-array wrap", MEMB - 2, 4);
    // R1 upper address bits are dropped
    beginFrame();
    xfer(8'h03, d);
    sendAddr(16'hFFC1);
    xfer(8'h00, d);
    endFrame();
    check8("R1 address truncation", d, model[1]);
    check8("R2 miso low after frame", {7'd0, miso}, 8'h00);

    report();
  end

endmodule